// File: doc/BRIEF.md
# Counterflow Convolution Array

This block is a linear chain of four multiply-accumulate cells that computes a four-tap discrete convolution of a stream of 8-bit signed samples with four 8-bit signed weights. Samples enter at the first cell and step one cell toward the last cell on every clock. Weights leave a four-entry ring and enter at the last cell, stepping one cell toward the first on every clock. Each cell keeps one running sum in place. Streams are interleaved with empty slots, so every sample meets every weight in some cell. A pair never swaps position between two cells without meeting.

When a cell multiplies by the first weight, its sum is complete. The cell places the sum on a neighbour-to-neighbour link that runs toward the output end, and then clears itself for the next output. No bus or global collection network is used. Results come out one every two clocks, in increasing index order, with a fixed latency. An 18-bit signed sum is large enough for any four products.

The user first writes the four weights, then offers one sample on every other cycle. A slot with no valid sample counts as a zero sample, which gives the zero extension at both ends of a sequence.

Top module: `cf_conv_array`

## Requirements
- R1: While rst_n is low, and after its release until results are due, res_vld is 0.
- R2: The four writes with wt_vld high after reset load the taps in order. The first write is w1, the weight that multiplies the newest sample. Computation uses the ring once all four writes have been made.
- R3: Cycles after reset release are numbered from 0, the cycle before the first rising edge. Samples are captured only in even-numbered cycles. A sample offered in an odd-numbered cycle is ignored.
- R4: For the sample slot k, the result is y(k) = w1·x(k) + w2·x(k-1) + w3·x(k-2) + w4·x(k-3). All values are signed, and the sum is 18 bits wide.
- R5: y(k) appears on res_dat exactly 5 cycles after the cycle in which x(k) was offered.
- R6: res_vld is high only for a result that has at least one valid sample among its four terms. A run of nine contiguous samples therefore gives exactly twelve results, in increasing index order.
- R7: res_vld is never high in two consecutive cycles, and at most one cell completes a result in any cycle.
- R8: An even-numbered cycle with smp_vld low is a zero sample, whatever smp_dat holds.
- R9: The weights recirculate without limit. A stream longer than the array keeps using the same four taps.
- R10: A cell that completes a result always finds its link stage free. Every result reaches the output intact through neighbour links alone, and each cell restarts its sum from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample present in this slot |
| smp_dat | input | 8 | Signed sample |
| wt_vld | input | 1 | Weight write strobe |
| wt_dat | input | 8 | Signed weight, written w1 first |
| res_vld | output | 1 | res_dat carries a completed result |
| res_dat | output | 18 | Signed convolution result |

## Verification
Three streams are used: the textbook sequence, a stream with extreme signed values longer than the array, and a stream with holes and with junk samples offered in odd cycles. A cycle-exact comparison is made on every cycle. If the block lost a crossing pair of operands, a term would be missing. If it mis-tagged the first weight, results would come out with the wrong sum or in the wrong cycle. If it let an odd-cycle sample through, or used the data of an invalid slot, the convolution would be corrupted. A wrong validity rule would show as thirteen results instead of twelve, or as a result inside a gap.

// File: rtl/cf_conv_array.sv
module cf_conv_array #(
  parameter int TAPS = 4,
  parameter int XW   = 8,
  parameter int WW   = 8,
  parameter int AW   = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [XW-1:0] smp_dat,
  input  logic                 wt_vld,
  input  logic signed [WW-1:0] wt_dat,
  output logic                 res_vld,
  output logic signed [AW-1:0] res_dat
);

  localparam int   PW     = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int   PRW    = XW + WW;
  localparam logic INJ_PH = 1'((TAPS - 1) % 2);
  localparam logic [PW-1:0] LAST_IDX = PW'(TAPS - 1);

  logic          tick;
  logic [PW-1:0] ld_ptr, rot_ptr;
  logic          wt_full;
  logic signed [WW-1:0] ring [TAPS];

  logic [TAPS-1:0]      xs_on, xs_hit;
  logic signed [XW-1:0] xs_d [TAPS];
  logic [TAPS-1:0]      ws_on, ws_last;
  logic signed [WW-1:0] ws_d [TAPS];
  logic signed [AW-1:0] acc  [TAPS];
  logic [TAPS-1:0]      acc_hit;
  logic [TAPS-1:0]      ch_on;
  logic signed [AW-1:0] ch_d [TAPS];

  logic [TAPS-1:0]       meet, fin, hit_sum;
  logic signed [PRW-1:0] prod [TAPS];
  logic signed [AW-1:0]  sum  [TAPS];

  wire slot_x = (tick == 1'b0);
  wire inj    = wt_full && (tick == INJ_PH);

  // weight ring: load in tap order, then rotate from the last tap down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= 1'b0;
      ld_ptr  <= '0;
      rot_ptr <= LAST_IDX;
      wt_full <= 1'b0;
      for (int i = 0; i < TAPS; i++) ring[i] <= '0;
    end else begin
      tick <= ~tick;
      if (wt_vld) begin
        ring[ld_ptr] <= wt_dat;
        ld_ptr <= (ld_ptr == LAST_IDX) ? '0 : ld_ptr + 1'b1;
        if (ld_ptr == LAST_IDX) wt_full <= 1'b1;
      end
      if (inj) rot_ptr <= (rot_ptr == '0) ? LAST_IDX : rot_ptr - 1'b1;
    end
  end

  for (genvar c = 0; c < TAPS; c++) begin : g_cell
    assign meet[c]    = xs_on[c] && ws_on[c];
    assign fin[c]     = meet[c] && ws_last[c];
    assign prod[c]    = PRW'(xs_d[c]) * PRW'(ws_d[c]);
    assign sum[c]     = acc[c] + AW'(prod[c]);
    assign hit_sum[c] = acc_hit[c] | xs_hit[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xs_on[c]   <= 1'b0;
        xs_hit[c]  <= 1'b0;
        xs_d[c]    <= '0;
        ws_on[c]   <= 1'b0;
        ws_last[c] <= 1'b0;
        ws_d[c]    <= '0;
        acc[c]     <= '0;
        acc_hit[c] <= 1'b0;
        ch_on[c]   <= 1'b0;
        ch_d[c]    <= '0;
      end else begin
        if (c == 0) begin
          xs_on[c]  <= slot_x;
          xs_hit[c] <= slot_x && smp_vld;
          xs_d[c]   <= (slot_x && smp_vld) ? smp_dat : '0;
        end else begin
          xs_on[c]  <= xs_on[c-1];
          xs_hit[c] <= xs_hit[c-1];
          xs_d[c]   <= xs_d[c-1];
        end
        if (c == TAPS - 1) begin
          ws_on[c]   <= inj;
          ws_last[c] <= inj && (rot_ptr == '0);
          ws_d[c]    <= ring[rot_ptr];
        end else begin
          ws_on[c]   <= ws_on[c+1];
          ws_last[c] <= ws_last[c+1];
          ws_d[c]    <= ws_d[c+1];
        end
        if (meet[c]) begin
          acc[c]     <= fin[c] ? '0   : sum[c];
          acc_hit[c] <= fin[c] ? 1'b0 : hit_sum[c];
        end
        if (fin[c]) begin
          ch_on[c] <= hit_sum[c];
          ch_d[c]  <= sum[c];
        end else if (c == 0) begin
          ch_on[c] <= 1'b0;
          ch_d[c]  <= '0;
        end else begin
          ch_on[c] <= ch_on[c-1];
          ch_d[c]  <= ch_d[c-1];
        end
      end
    end

    if (c > 0) begin : g_link_chk
      AST_LINK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fin[c] |-> !ch_on[c-1]); // R10
    end
    if (c < TAPS - 1) begin : g_cross_chk
      AST_NO_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
        !(xs_on[c] && ws_on[c+1])); // R4
    end
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fin[c] |=> (acc[c] == '0) && !acc_hit[c]); // R10
  end

  assign res_vld = ch_on[TAPS-1];
  assign res_dat = ch_d[TAPS-1];

  AST_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && tick) |=> !xs_hit[0]); // R3
  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld); // R7
  AST_ONE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin)); // R7

endmodule

// File: tb/cf_conv_array_tb_top.sv
module cf_conv_array_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [7:0] smp_dat = '0;
  logic wt_vld = 1'b0;
  logic signed [7:0] wt_dat = '0;
  logic res_vld;
  logic signed [17:0] res_dat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cf_conv_array dut_i (
    .clk(clk), .rst_n(rst_n),
    .smp_vld(smp_vld), .smp_dat(smp_dat),
    .wt_vld(wt_vld), .wt_dat(wt_dat),
    .res_vld(res_vld), .res_dat(res_dat)
  );

  localparam int W_A[4]  = '{1, 2, 2, 1};
  localparam int X_A[16] = '{11, 2, 3, 4, 5, 6, 3, 2, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam bit [15:0] V_A = 16'h01FF;
  localparam int Y_A[12] = '{11, 24, 29, 25, 21, 27, 29, 25, 17, 9, 4, 1};

  localparam int W_B[4]  = '{-128, 127, -1, 5};
  localparam int X_B[16] = '{-128, 127, -128, 127, 0, 1, -1, 100,
                             -100, 50, -50, 7, -7, 127, -128, 3};
  localparam bit [15:0] V_B = 16'hFFFF;

  localparam int W_C[4]  = '{3, -2, 0, 1};
  localparam int X_C[16] = '{9, 0, -4, 6, 0, 0, 0, 0, 5, 0, 0, 0, 0, 0, 0, 0};
  localparam bit [15:0] V_C = 16'h010D;

  int wts[4];
  int xs[16];
  bit [15:0] xv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_y(input int s);
    int acc = 0;
    for (int j = 0; j < 4; j++)
      if (s - j >= 0 && s - j < 16 && xv[s-j]) acc += xs[s-j] * wts[j];
    return acc;
  endfunction

  function automatic bit ref_hit(input int s);
    bit h = 0;
    for (int j = 0; j < 4; j++)
      if (s - j >= 0 && s - j < 16 && xv[s-j]) h = 1;
    return h;
  endfunction

  // slot s offered in cycle 10+2s; its result due in cycle 15+2s (R5)
  task automatic run_case(input string name, input bit noise, input bit use_tab, output int nres);
    nres = 0;
    @(negedge clk);
    rst_n = 1'b0;
    smp_vld = 1'b0;
    wt_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk(res_vld == 1'b0, "R1 reset", int'(res_vld), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 60; cyc++) begin
      wt_vld  = (cyc < 4);
      wt_dat  = (cyc < 4) ? 8'(wts[cyc]) : 8'sd0;
      smp_vld = 1'b0;
      smp_dat = 8'sd33;
      if (cyc >= 10 && cyc % 2 == 0 && (cyc - 10) / 2 < 16) begin
        smp_vld = xv[(cyc-10)/2];
        smp_dat = 8'(xs[(cyc-10)/2]);
      end else if (noise && cyc % 2 == 1) begin
        smp_vld = 1'b1;
        smp_dat = -8'sd77;
      end
      if (cyc >= 15 && cyc % 2 == 1) begin
        int s = (cyc - 15) / 2;
        bit eh = ref_hit(s);
        int ey = ref_y(s);
        if (use_tab && s < 12) ey = Y_A[s];
        chk(res_vld == eh, "R6 valid", int'(res_vld), int'(eh));
        if (eh && res_vld) begin
          chk(int'(res_dat) == ey, "R4 R5 R10 value", int'(res_dat), ey);
          nres++;
        end
      end else begin
        chk(res_vld == 1'b0, (cyc < 15) ? "R1 idle" : "R7 spacing", int'(res_vld), 0);
      end
      @(negedge clk);
    end
    wt_vld = 1'b0;
    smp_vld = 1'b0;
    $display("case %s: %0d results", name, nres);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    // case A: textbook stream, table of expected outputs (R2 R4 R5 R6)
    wts = W_A; xs = X_A; xv = V_A;
    for (int s = 0; s < 12; s++)
      chk(ref_y(s) == Y_A[s], "R4 table model", ref_y(s), Y_A[s]);
    run_case("A", 1'b0, 1'b1, n);
    chk(n == 12, "R6 nine samples give twelve results", n, 12);

    // case B: extreme signed values, stream longer than the array (R9 R4)
    wts = W_B; xs = X_B; xv = V_B;
    run_case("B", 1'b0, 1'b0, n);
    chk(n == 19, "R9 long stream result count", n, 19);

    // case C: holes with junk data and odd-cycle samples (R3 R8 R6)
    wts = W_C; xs = X_C; xv = V_C;
    run_case("C", 1'b1, 1'b0, n);
    chk(n == 11, "R3 R8 gap and ignored samples", n, 11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule